// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block is the per-port logic of a general-purpose I/O bank. A simple register bus writes and reads one byte of configuration per function. Each pin has its own bit for output data, direction, reduced drive, pull enable, polarity, wired-or and interrupt enable. The block drives the pad's output enable and output data. It exports the drive and pull controls as plain bits and samples the pad level through a two-flop synchronizer. An on-chip peripheral can claim any pin through a per-pin ownership input. While it holds the pin, its own enable and data reach the pad and the pin's direction bit has no effect.

Each pin can raise an edge interrupt. Its polarity bit picks the falling or the rising edge, and a write-1-to-clear flag register records the event. The single interrupt request is high while any pin has both its flag and its enable set. The data address has a split read path: output pins return the stored bit and input pins return the live synchronized level. A second, read-only address always returns the synchronized level.

The bus carries no stream of data, so it has no valid/ready handshake and never stalls. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high, and is 0 otherwise.

Top module: `gpio_port`

## Requirements
- R1: After reset every configuration register and every interrupt flag is 0. All `pad_oe` bits are 0, `pad_out` is 0 and `irq` is 0.
- R2: A direction bit of 1 makes its pin a GPIO output with `pad_oe`=1 and `pad_out` equal to the stored data bit. A direction bit of 0 makes it an input with `pad_oe`=0.
- R3: A read of the data address (0x0) returns the stored data bit for pins whose direction bit is 1. It returns the synchronized pad level for pins whose direction bit is 0.
- R4: A read of the pin address (0x1) always returns the synchronized pad level, whatever the direction. Writes to 0x1 change nothing.
- R5: A change on `pad_in` reaches register reads after two clock edges and not after one.
- R6: Where `periph_own` is 1, `pad_oe` and `pad_out` for that pin equal `periph_oe` and `periph_out`, and the direction, data and wired-or bits have no effect on that pin.
- R7: With the wired-or bit set, a GPIO output pin with stored 1 has `pad_oe`=0 and a pin with stored 0 drives low (`pad_oe`=1, `pad_out`=0). No wired-or pin ever drives high.
- R8: `pad_pull_en` follows the pull-enable register. `pad_pull_dn` is the polarity bit ANDed with pull enable (1 means pull down). `pad_rdrv` follows the reduced-drive register.
- R9: With polarity 0 a pin's flag sets one edge after its synchronized level falls. With polarity 1 it sets on a rise. The other edge direction sets nothing.
- R10: Writing 1 to a bit of the flag register (0x8) clears that flag. Writing 0 leaves it unchanged.
- R11: If an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R12: `irq` is 1 exactly when some pin has both its flag and its interrupt-enable bit set.
- R13: The configuration registers read back as written at these addresses: data 0x0, direction 0x2, reduced drive 0x3, pull enable 0x4, polarity 0x5, wired-or 0x6, interrupt enable 0x7, flags 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output data |
| pad_pull_en | output | 8 | Pull resistor enable |
| pad_pull_dn | output | 8 | Pull direction, 1 = down |
| pad_rdrv | output | 8 | Reduced drive select |
| periph_own | input | 8 | Peripheral owns the pin |
| periph_oe | input | 8 | Peripheral output enable |
| periph_out | input | 8 | Peripheral output data |
| irq | output | 1 | Interrupt request |

## Verification
The bench mixes directions within one byte, so a data read that returns only the stored value, or only the pin level, shows wrong bits. It checks a pad change after one edge and after two, which catches a synchronizer with a missing or an extra stage. It lines up a clear write with an edge that sets the same flag: a design where the clear wins reads the flag back as 0. A design that detects the wrong edge sets the flag on the rising edge instead. Ownership and wired-or cases sit in the same bytes as plain GPIO pins, so an override that leaks to a neighbouring pin, or a wired-or pin that drives high, changes the pad bytes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 4'h0,
    REG_PIN    = 4'h1,
    REG_DIR    = 4'h2,
    REG_RDRV   = 4'h3,
    REG_PULLEN = 4'h4,
    REG_POL    = 4'h5,
    REG_WOR    = 4'h6,
    REG_IEN    = 4'h7,
    REG_IFLAG  = 4'h8
  } reg_addr_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_addr_e        addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] rdrv_q,
  output logic [WIDTH-1:0] pullen_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] wor_q,
  output logic [WIDTH-1:0] ien_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      rdrv_q   <= '0;
      pullen_q <= '0;
      pol_q    <= '0;
      wor_q    <= '0;
      ien_q    <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DATA:   data_q   <= wdata;
        REG_DIR:    dir_q    <= wdata;
        REG_RDRV:   rdrv_q   <= wdata;
        REG_PULLEN: pullen_q <= wdata;
        REG_POL:    pol_q    <= wdata;
        REG_WOR:    wor_q    <= wdata;
        REG_IEN:    ien_q    <= wdata;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_padctl.sv
module gpio_port_padctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] wor_q,
  input  logic [WIDTH-1:0] pullen_q,
  input  logic [WIDTH-1:0] pol_q,
  input  logic [WIDTH-1:0] periph_own,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] periph_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pull_en,
  output logic [WIDTH-1:0] pad_pull_dn
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic gpio_oe;
    logic gpio_out;

    always_comb begin
      if (wor_q[i]) begin
        gpio_oe  = dir_q[i] & ~data_q[i];
        gpio_out = 1'b0;
      end else begin
        gpio_oe  = dir_q[i];
        gpio_out = data_q[i];
      end
    end

    assign pad_oe[i]      = periph_own[i] ? periph_oe[i]  : gpio_oe;
    assign pad_out[i]     = periph_own[i] ? periph_out[i] : gpio_out;
    assign pad_pull_en[i] = pullen_q[i];
    assign pad_pull_dn[i] = pullen_q[i] & pol_q[i];
  end

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_s,
  input  logic [WIDTH-1:0] pol_q,
  input  logic [WIDTH-1:0] ien_q,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] flag_q,
  output logic             irq
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    logic rise;
    logic fall;
    assign rise   = pin_s[i] & ~prev_q[i];
    assign fall   = ~pin_s[i] & prev_q[i];
    assign hit[i] = pol_q[i] ? rise : fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= pin_s;
      flag_q <= (flag_q & ~clr_mask) | hit;
    end
  end

  assign irq = |(flag_q & ien_q);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pull_en,
  output logic [WIDTH-1:0]  pad_pull_dn,
  output logic [WIDTH-1:0]  pad_rdrv,
  input  logic [WIDTH-1:0]  periph_own,
  input  logic [WIDTH-1:0]  periph_oe,
  input  logic [WIDTH-1:0]  periph_out,
  output logic              irq
);

  reg_addr_e        addr;
  logic             wr_en;
  logic [WIDTH-1:0] data_q, dir_q, rdrv_q, pullen_q, pol_q, wor_q, ien_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] clr_mask;

  assign addr     = reg_addr_e'(bus_addr);
  assign wr_en    = bus_sel & bus_wr;
  assign clr_mask = (wr_en && addr == REG_IFLAG) ? bus_wdata : '0;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .rdrv_q(rdrv_q), .pullen_q(pullen_q),
    .pol_q(pol_q), .wor_q(wor_q), .ien_q(ien_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  gpio_port_padctl #(.WIDTH(WIDTH)) u_padctl (
    .data_q(data_q), .dir_q(dir_q), .wor_q(wor_q), .pullen_q(pullen_q),
    .pol_q(pol_q), .periph_own(periph_own), .periph_oe(periph_oe),
    .periph_out(periph_out), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn)
  );

  gpio_port_irq #(.WIDTH(WIDTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pol_q(pol_q), .ien_q(ien_q),
    .clr_mask(clr_mask), .flag_q(flag_q), .irq(irq)
  );

  assign pad_rdrv = rdrv_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (addr)
        REG_DATA:   bus_rdata = (data_q & dir_q) | (pin_s & ~dir_q);
        REG_PIN:    bus_rdata = pin_s;
        REG_DIR:    bus_rdata = dir_q;
        REG_RDRV:   bus_rdata = rdrv_q;
        REG_PULLEN: bus_rdata = pullen_q;
        REG_POL:    bus_rdata = pol_q;
        REG_WOR:    bus_rdata = wor_q;
        REG_IEN:    bus_rdata = ien_q;
        REG_IFLAG:  bus_rdata = flag_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [WIDTH-1:0] periph_own,
  input logic [WIDTH-1:0] periph_oe,
  input logic [WIDTH-1:0] periph_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_pull_en,
  input logic [WIDTH-1:0] pad_pull_dn,
  input logic             irq,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] wor_q,
  input logic [WIDTH-1:0] ien_q,
  input logic [WIDTH-1:0] flag_q
);

  logic flag_wr;
  assign flag_wr = bus_sel && bus_wr && (bus_addr == 4'h8);

  AST_OWN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ periph_oe) | (pad_out ^ periph_out)) & periph_own) == '0); // R6

  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q & ~periph_own) == '0); // R2

  AST_WOR_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & wor_q & ~periph_own) == '0); // R7

  AST_PULL_DN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_dn & ~pad_pull_en) == '0); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((~flag_q & $past(flag_q)) == '0)); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R12

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq); // R12

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .periph_own(periph_own), .periph_oe(periph_oe),
  .periph_out(periph_out), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn), .irq(irq),
  .dir_q(dir_q), .wor_q(wor_q), .ien_q(ien_q), .flag_q(flag_q)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;

  localparam int W = 8;

  localparam logic [3:0] A_DATA = 4'h0, A_PIN = 4'h1, A_DIR = 4'h2, A_RDRV = 4'h3,
                         A_PULLEN = 4'h4, A_POL = 4'h5, A_WOR = 4'h6, A_IEN = 4'h7,
                         A_IFLAG = 4'h8;

  // {dir, data, wor, own, periph_oe, periph_out, pad_in, exp_oe, exp_out, exp_rdata}
  localparam int NV = 7;
  localparam logic [79:0] VEC [NV] = '{
    80'hFF_A5_00_00_00_00_00_FF_A5_A5,  // R2 all outputs
    80'h00_A5_00_00_00_00_3C_00_A5_3C,  // R2 R3 all inputs
    80'hF0_55_00_00_00_00_0F_F0_55_5F,  // R3 mixed directions
    80'hFF_0F_FF_00_00_00_00_F0_00_0F,  // R7 wired-or everywhere
    80'hFF_FF_00_0F_05_03_81_F5_F3_FF,  // R6 low nibble owned
    80'h00_00_00_F0_F0_A0_C3_F0_A0_C3,  // R6 owned inputs
    80'h0F_3C_33_00_00_00_F0_0F_0C_FC   // R7 R3 mixed wired-or
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] pad_in = '0, pad_oe, pad_out, pad_pull_en, pad_pull_dn, pad_rdrv;
  logic [W-1:0] periph_own = '0, periph_oe = '0, periph_out = '0;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn), .pad_rdrv(pad_rdrv),
    .periph_own(periph_own), .periph_oe(periph_oe), .periph_out(periph_out),
    .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(A_DIR, v);   check("R1 dir", v, 8'h00);
    rd(A_IEN, v);   check("R1 ien", v, 8'h00);
    rd(A_IFLAG, v); check("R1 flags", v, 8'h00);

    // R5 synchronizer latency
    pad_in = 8'h5A;
    tick();
    rd(A_PIN, v); check("R5 one edge", v, 8'h00);
    tick();
    rd(A_PIN, v); check("R5 two edges", v, 8'h5A);

    // R4 pin register ignores writes
    wr(A_PIN, 8'hFF);
    rd(A_PIN, v); check("R4 pin write ignored", v, 8'h5A);
    check("R4 pad_oe unchanged", pad_oe, 8'h00);

    // vector table: R2 R3 R6 R7
    for (int k = 0; k < NV; k++) begin
      periph_own = VEC[k][55:48];
      periph_oe  = VEC[k][47:40];
      periph_out = VEC[k][39:32];
      pad_in     = VEC[k][31:24];
      wr(A_DIR,  VEC[k][79:72]);
      wr(A_DATA, VEC[k][71:64]);
      wr(A_WOR,  VEC[k][63:56]);
      tick();
      check($sformatf("R2 R6 R7 pad_oe vec%0d", k), pad_oe, VEC[k][23:16]);
      check($sformatf("R2 R6 R7 pad_out vec%0d", k), pad_out, VEC[k][15:8]);
      rd(A_DATA, v); check($sformatf("R3 data read vec%0d", k), v, VEC[k][7:0]);
      rd(A_PIN, v);  check($sformatf("R4 pin read vec%0d", k), v, VEC[k][31:24]);
    end
    periph_own = '0; periph_oe = '0; periph_out = '0;
    wr(A_DIR, 8'h00); wr(A_WOR, 8'h00);

    // R13 readback, R8 exported controls
    wr(A_RDRV, 8'h81); wr(A_PULLEN, 8'h0F); wr(A_POL, 8'h05); wr(A_IEN, 8'h3C);
    rd(A_RDRV, v);   check("R13 rdrv", v, 8'h81);
    rd(A_PULLEN, v); check("R13 pullen", v, 8'h0F);
    rd(A_POL, v);    check("R13 pol", v, 8'h05);
    rd(A_IEN, v);    check("R13 ien", v, 8'h3C);
    check("R8 rdrv", pad_rdrv, 8'h81);
    check("R8 pull_en", pad_pull_en, 8'h0F);
    check("R8 pull_dn", pad_pull_dn, 8'h05);
    wr(A_POL, 8'hF2);
    check("R8 pull_dn gated", pad_pull_dn, 8'h02);

    // interrupt setup: bit0 falling, bit1 rising
    wr(A_PULLEN, 8'h00);
    wr(A_IEN, 8'h00);
    pad_in = 8'h00;
    repeat (4) tick();
    wr(A_IFLAG, 8'hFF);
    rd(A_IFLAG, v); check("R10 clear all", v, 8'h00);
    wr(A_POL, 8'h02);
    wr(A_IEN, 8'h01);

    // R9 rising edge on falling-polarity pin sets nothing
    pad_in = 8'h01;
    repeat (4) tick();
    rd(A_IFLAG, v); check("R9 wrong edge ignored", v, 8'h00);
    check("R12 irq idle", {7'd0, irq}, 8'h00);

    // R9 falling edge: flag after the third edge
    pad_in = 8'h00;
    tick(); tick();
    rd(A_IFLAG, v); check("R9 not yet set", v, 8'h00);
    tick();
    rd(A_IFLAG, v); check("R9 falling sets", v, 8'h01);
    check("R12 irq on", {7'd0, irq}, 8'h01);

    // R9 rising on polarity-1 pin
    pad_in = 8'h02;
    repeat (3) tick();
    rd(A_IFLAG, v); check("R9 rising sets", v, 8'h03);

    // R10 write-1-to-clear
    wr(A_IFLAG, 8'h00);
    rd(A_IFLAG, v); check("R10 zero write", v, 8'h03);
    wr(A_IFLAG, 8'h01);
    rd(A_IFLAG, v); check("R10 clear bit0", v, 8'h02);
    check("R12 unenabled flag", {7'd0, irq}, 8'h00);
    wr(A_IFLAG, 8'h02);
    rd(A_IFLAG, v); check("R10 clear bit1", v, 8'h00);

    // R11 set wins over simultaneous clear
    pad_in = 8'h01;
    repeat (4) tick();
    rd(A_IFLAG, v); check("R11 precondition", v, 8'h00);
    pad_in = 8'h00;
    tick(); tick();
    wr(A_IFLAG, 8'h01);
    rd(A_IFLAG, v); check("R11 set wins", v, 8'h01);
    check("R11 irq", {7'd0, irq}, 8'h01);
    wr(A_IFLAG, 8'h01);
    rd(A_IFLAG, v); check("R10 plain clear", v, 8'h00);
    check("R12 irq off", {7'd0, irq}, 8'h00);

    finish_run();
  end

endmodule